// File: doc/BRIEF.md
# Comma-Detect Symbol Aligner

This block sits behind a 10-bit deserializer. The deserializer delivers one 10-bit word per symbol clock, and the word boundary in that stream is arbitrary. The block finds the true symbol boundary by looking for the comma character (K28.5) in every possible bit rotation. It then holds that boundary and delivers aligned 10-bit symbols to the downstream buffer and decoder. When a receive-polarity control is set, every incoming bit is flipped before it is stored or searched.

The block keeps two consecutive words as a 20-bit window and tests all ten candidate offsets in the same cycle. One comma only nominates an offset. A second comma at the same offset declares symbol lock, and the offset is then frozen. Lock is lost in two cases: a comma turns up at some other offset, or too many symbols pass with no comma at the locked offset. The output valid flag is the received-data qualifier. It is high only for symbols produced while lock is held. The deserializer cannot be stalled, so there is no ready signal. Each accepted input word produces exactly one output cycle, one clock later, and the consumer must take every valid symbol as it comes.

Top module: `comma_aligner`

## Requirements
- R1: After reset, `lock`, `sym_valid` and `sym_comma` are low and the block is hunting for a comma.
- R2: While `rx_invert` is 1, every bit of `in_word` is inverted before it is stored and searched. A stream sent inverted therefore yields the original symbols on `sym_data`.
- R3: `in_word[0]` is the earliest received bit. The search window is {current word, previous accepted word}, with the previous word in bits 9:0. Offset k (0..9) selects window bits k+9:k. A candidate is a comma when it equals 10'h17C or 10'h283, which are K28.5 in its two disparity forms sent first-bit-first as 0011111010 and 1100000101. When several offsets match, the lowest offset is taken.
- R4: Lock is declared when a second comma is found at the same offset as the nominated one. A single comma never sets `lock`. A comma at a different offset while nominated replaces the nomination.
- R5: While locked, the offset does not change. A comma at a different offset, with none at the locked offset, drops lock. That comma becomes the new nomination.
- R6: MAX_GAP consecutive accepted words with no comma at the current offset drop a lock or a nomination back to hunting. MAX_GAP-1 such words keep lock.
- R7: For each accepted word, one clock later `sym_data` holds the window bits at the offset in force after that word. `sym_valid` is high in that cycle only if the block is locked after that word.
- R8: `sym_comma` is high in the same cycle as a symbol on `sym_data` that is a comma.
- R9: A cycle with `in_valid` low changes no alignment state and gives `sym_valid` and `sym_comma` low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | `in_word` carries a new deserialized word this cycle |
| in_word | input | 10 | Raw deserialized bits, bit 0 received first |
| rx_invert | input | 1 | Invert all received bits before alignment |
| sym_data | output | 10 | Aligned symbol |
| sym_valid | output | 1 | Received-data qualifier: aligned symbol produced under lock |
| sym_comma | output | 1 | Aligned symbol is a comma |
| lock | output | 1 | Symbol lock held |

## Verification
The checker watches the invariants on every cycle. A valid symbol only appears while lock is held, and the offset stays frozen across locked cycles. Every flagged comma really is one of the two K28.5 forms. A rising lock always coincides with a comma on the output, an idle input cycle yields no valid symbol, and a checker counter shows that the locked output never runs MAX_GAP symbols without a comma. Only the bench scenarios can show that alignment is correct for a given bit slip, that polarity inversion recovers the original data, and that a slipped comma or a gap of exactly MAX_GAP symbols drops lock while one symbol fewer does not. The bench does this by comparing against a behavioural model each clock.

// File: rtl/comma_align_pkg.sv
package comma_align_pkg;
  localparam int SYM_W = 10;
  localparam int OFF_W = $clog2(SYM_W);
  localparam int WIN_W = 2 * SYM_W;
  // K28.5 with bit 0 as the first bit on the line
  localparam logic [SYM_W-1:0] COMMA_NEG = 10'h17C;
  localparam logic [SYM_W-1:0] COMMA_POS = ~COMMA_NEG;

  typedef enum logic [1:0] {
    ST_HUNT = 2'd0,
    ST_CAND = 2'd1,
    ST_LOCK = 2'd2
  } align_st_e;

  function automatic logic is_comma(input logic [SYM_W-1:0] s);
    return (s == COMMA_NEG) || (s == COMMA_POS);
  endfunction
endpackage

// File: rtl/comma_align_scan.sv
module comma_align_scan
  import comma_align_pkg::*;
(
  input  logic [WIN_W-1:0] win,
  output logic [SYM_W-1:0] hit,
  output logic             any_hit,
  output logic [OFF_W-1:0] first_hit
);
  // one comparator per bit rotation
  for (genvar k = 0; k < SYM_W; k++) begin : g_off
    assign hit[k] = is_comma(win[k +: SYM_W]);
  end

  always_comb begin
    first_hit = '0;
    for (int k = SYM_W - 1; k >= 0; k--) begin
      if (hit[k]) first_hit = OFF_W'(k);
    end
    any_hit = |hit;
  end
endmodule

// File: rtl/comma_align_lock.sv
module comma_align_lock
  import comma_align_pkg::*;
#(
  parameter int MAX_GAP = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic [SYM_W-1:0] hit,
  input  logic             any_hit,
  input  logic [OFF_W-1:0] first_hit,
  output logic [OFF_W-1:0] off_q,
  output logic [OFF_W-1:0] off_n,
  output align_st_e        st_q,
  output align_st_e        st_n
);
  localparam int CNT_W = $clog2(MAX_GAP + 1);

  logic [CNT_W-1:0] gap_q, gap_n;
  logic             same_hit;
  logic             gap_full;

  assign same_hit = hit[off_q];
  assign gap_full = (gap_q == CNT_W'(MAX_GAP - 1));

  always_comb begin
    st_n  = st_q;
    off_n = off_q;
    gap_n = gap_q;
    if (step) begin
      unique case (st_q)
        ST_HUNT: begin
          if (any_hit) begin
            st_n  = ST_CAND;
            off_n = first_hit;
            gap_n = '0;
          end
        end
        ST_CAND, ST_LOCK: begin
          if (same_hit) begin
            st_n  = ST_LOCK;
            gap_n = '0;
          end else if (any_hit) begin
            st_n  = ST_CAND;
            off_n = first_hit;
            gap_n = '0;
          end else if (gap_full) begin
            st_n  = ST_HUNT;
            gap_n = '0;
          end else begin
            gap_n = gap_q + 1'b1;
          end
        end
        default: begin
          st_n  = ST_HUNT;
          gap_n = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_HUNT;
      off_q <= '0;
      gap_q <= '0;
    end else begin
      st_q  <= st_n;
      off_q <= off_n;
      gap_q <= gap_n;
    end
  end
endmodule

// File: rtl/comma_align_out.sv
module comma_align_out
  import comma_align_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic [WIN_W-1:0] win,
  input  logic [SYM_W-1:0] hit,
  input  logic [OFF_W-1:0] off_n,
  input  logic             lock_n,
  output logic [SYM_W-1:0] sym_data,
  output logic             sym_valid,
  output logic             sym_comma
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sym_data  <= '0;
      sym_valid <= 1'b0;
      sym_comma <= 1'b0;
    end else begin
      sym_valid <= step && lock_n;
      sym_comma <= step && hit[off_n];
      if (step) sym_data <= win[off_n +: SYM_W];
    end
  end
endmodule

// File: rtl/comma_aligner.sv
module comma_aligner
  import comma_align_pkg::*;
#(
  parameter int MAX_GAP = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [SYM_W-1:0] in_word,
  input  logic             rx_invert,
  output logic [SYM_W-1:0] sym_data,
  output logic             sym_valid,
  output logic             sym_comma,
  output logic             lock
);
  logic [SYM_W-1:0] word_fix;
  logic [SYM_W-1:0] prev_q;
  logic [WIN_W-1:0] win;
  logic [SYM_W-1:0] hit;
  logic             any_hit;
  logic [OFF_W-1:0] first_hit;
  logic [OFF_W-1:0] align_off;
  logic [OFF_W-1:0] align_off_n;
  align_st_e        st_q, st_n;

  assign word_fix = in_word ^ {SYM_W{rx_invert}};
  assign win      = {word_fix, prev_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else if (in_valid) prev_q <= word_fix;
  end

  comma_align_scan u_scan (
    .win       (win),
    .hit       (hit),
    .any_hit   (any_hit),
    .first_hit (first_hit)
  );

  comma_align_lock #(.MAX_GAP(MAX_GAP)) u_lock (
    .clk       (clk),
    .rst_n     (rst_n),
    .step      (in_valid),
    .hit       (hit),
    .any_hit   (any_hit),
    .first_hit (first_hit),
    .off_q     (align_off),
    .off_n     (align_off_n),
    .st_q      (st_q),
    .st_n      (st_n)
  );

  comma_align_out u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .step      (in_valid),
    .win       (win),
    .hit       (hit),
    .off_n     (align_off_n),
    .lock_n    (st_n == ST_LOCK),
    .sym_data  (sym_data),
    .sym_valid (sym_valid),
    .sym_comma (sym_comma)
  );

  assign lock = (st_q == ST_LOCK);
endmodule

// File: rtl/comma_align_chk.sv
module comma_align_chk
  import comma_align_pkg::*;
#(
  parameter int MAX_GAP = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [SYM_W-1:0] sym_data,
  input logic             sym_valid,
  input logic             sym_comma,
  input logic             lock,
  input logic [OFF_W-1:0] off
);
  int gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gap_q <= 0;
    else if (!lock) gap_q <= 0;
    else if (sym_valid) gap_q <= sym_comma ? 0 : gap_q + 1;
  end

  a_r7_valid_needs_lock: assert property (@(posedge clk) disable iff (!rst_n)
    sym_valid |-> lock);

  a_r5_offset_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && $past(lock)) |-> $stable(off));

  a_r8_comma_is_k285: assert property (@(posedge clk) disable iff (!rst_n)
    sym_comma |-> (sym_data == COMMA_NEG || sym_data == COMMA_POS));

  a_r4_lock_on_comma: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock) |-> sym_comma);

  a_r9_idle_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!sym_valid && !sym_comma));

  a_r6_gap_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    lock |-> (gap_q < MAX_GAP));
endmodule

bind comma_aligner comma_align_chk #(.MAX_GAP(MAX_GAP)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .sym_data  (sym_data),
  .sym_valid (sym_valid),
  .sym_comma (sym_comma),
  .lock      (lock),
  .off       (align_off)
);

// File: tb/comma_aligner_tb.sv
module comma_aligner_tb;
  localparam int GAP = 16;
  localparam logic [9:0] CN = 10'h17C;
  localparam logic [9:0] CP = 10'h283;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [9:0] in_word = '0;
  logic       rx_invert = 1'b0;
  logic [9:0] sym_data;
  logic       sym_valid, sym_comma, lock;

  comma_aligner #(.MAX_GAP(GAP)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
    .rx_invert(rx_invert), .sym_data(sym_data), .sym_valid(sym_valid),
    .sym_comma(sym_comma), .lock(lock)
  );

  always #4 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  bit bq[$];
  int didx = 0;
  logic [9:0] dtbl [5] = '{10'h2AA, 10'h155, 10'h2CD, 10'h133, 10'h0CB};

  // behavioural reference state
  int m_st, m_off, m_cnt;
  logic [9:0] m_prev, e_sym;
  bit e_vld, e_cm, e_lock, cmp_on;

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic void m_reset();
    m_st = 0; m_off = 0; m_cnt = 0; m_prev = '0;
    e_sym = '0; e_vld = 0; e_cm = 0; e_lock = 0;
  endfunction

  function automatic void m_step(bit v, logic [9:0] w);
    logic [19:0] win;
    bit hits [10];
    int first;
    if (!v) begin e_vld = 0; e_cm = 0; return; end
    win = {w, m_prev};
    first = -1;
    for (int k = 0; k < 10; k++) begin
      hits[k] = (win[k +: 10] == CN) || (win[k +: 10] == CP);
      if (first < 0 && hits[k]) first = k;
    end
    if (m_st == 0) begin
      if (first >= 0) begin m_st = 1; m_off = first; m_cnt = 0; end
    end else begin
      if (hits[m_off]) begin m_st = 2; m_cnt = 0; end
      else if (first >= 0) begin m_st = 1; m_off = first; m_cnt = 0; end
      else if (m_cnt + 1 == GAP) begin m_st = 0; m_cnt = 0; end
      else m_cnt++;
    end
    e_sym = win[m_off +: 10];
    e_vld = (m_st == 2);
    e_cm = hits[m_off];
    e_lock = (m_st == 2);
    m_prev = w;
  endfunction

  task automatic compare();
    if (!cmp_on) return;
    chk(sym_valid === e_vld, "R7 sym_valid", sym_valid, e_vld);
    chk(sym_data === e_sym, "R7 sym_data", sym_data, e_sym);
    chk(sym_comma === e_cm, "R8 sym_comma", sym_comma, e_cm);
    chk(lock === e_lock, "R4 lock", lock, e_lock);
  endtask

  task automatic step(bit v, logic [9:0] w);
    @(negedge clk);
    compare();
    in_valid = v;
    in_word = w;
    m_step(v, w ^ {10{rx_invert}});
  endtask

  task automatic settle();
    step(1'b0, 10'h3FF);
    @(negedge clk);
    compare();
  endtask

  task automatic do_reset();
    @(negedge clk);
    cmp_on = 0;
    rst_n = 0; in_valid = 0; rx_invert = 0;
    bq.delete();
    m_reset();
    @(negedge clk);
    @(negedge clk);
    rst_n = 1;
    cmp_on = 1;
  endtask

  task automatic push_sym(logic [9:0] s);
    for (int i = 0; i < 10; i++) bq.push_back(s[i]);
  endtask

  task automatic push_data(int n);
    for (int i = 0; i < n; i++) begin
      push_sym(dtbl[didx % 5]);
      didx++;
    end
  endtask

  task automatic feed();
    logic [9:0] w;
    while (bq.size() >= 10) begin
      for (int i = 0; i < 10; i++) w[i] = bq.pop_front();
      step(1'b1, w);
    end
  endtask

  initial begin
    m_reset();
    cmp_on = 0;
    do_reset();
    @(negedge clk);
    chk(lock === 1'b0, "R1 lock after reset", lock, 0);
    chk(sym_valid === 1'b0, "R1 sym_valid after reset", sym_valid, 0);
    chk(sym_comma === 1'b0, "R1 sym_comma after reset", sym_comma, 0);

    // slip of 3 bits, one comma only: no lock
    bq.push_back(1); bq.push_back(0); bq.push_back(1);
    push_sym(CN); push_data(8);
    feed(); settle();
    chk(lock === 1'b0, "R4 single comma no lock", lock, 0);

    // second comma at same offset: lock
    push_sym(CP); push_data(3);
    feed(); settle();
    chk(lock === 1'b1, "R4 second comma locks", lock, 1);
    chk(sym_valid === 1'b0, "R9 idle gives no valid", sym_valid, 0);

    // idle cycles interleaved while locked
    push_data(2);
    feed();
    step(1'b0, 10'h0F8); step(1'b0, 10'h307);
    settle();
    chk(lock === 1'b1, "R9 idle keeps lock", lock, 1);

    // one extra bit slips the boundary: comma at a new offset drops lock
    bq.push_back(1);
    push_sym(CN); push_data(3);
    feed(); settle();
    chk(lock === 1'b0, "R5 comma at new offset drops lock", lock, 0);
    push_sym(CP); push_data(3);
    feed(); settle();
    chk(lock === 1'b1, "R5 relock at new offset", lock, 1);

    // gap boundary with no slip
    do_reset();
    push_sym(CN); push_data(3); push_sym(CP);
    feed();
    push_data(GAP);
    feed(); settle();
    chk(lock === 1'b1, "R6 GAP-1 silent symbols keep lock", lock, 1);
    push_data(1);
    feed(); settle();
    chk(lock === 1'b0, "R6 GAP silent symbols drop lock", lock, 0);

    // polarity inversion, no slip
    do_reset();
    rx_invert = 1;
    push_sym(~CN); push_sym(~dtbl[0]); push_sym(~dtbl[1]); push_sym(~dtbl[2]);
    push_sym(~CP); push_sym(~dtbl[3]); push_sym(~dtbl[4]);
    feed(); settle();
    chk(lock === 1'b1, "R2 lock under inversion", lock, 1);
    chk(sym_data === dtbl[3], "R2 recovered symbol", sym_data, dtbl[3]);

    // lowest offset wins on a stream with a slip of 7
    do_reset();
    for (int i = 0; i < 7; i++) bq.push_back(i[0]);
    for (int r = 0; r < 6; r++) begin push_sym(r[0] ? CP : CN); push_data(4); end
    feed(); settle();
    chk(lock === 1'b1, "R3 lock with slip 7", lock, 1);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule